// File: doc/BRIEF.md
# First-Order Masked 4-bit Substitution Box

This block evaluates a cubic 4-bit substitution box on a value that never exists in the clear. The nibble arrives as two Boolean shares whose XOR is the true input. The block returns two Boolean shares whose XOR is the substituted nibble. The box is the one used in a low-latency 64-bit block cipher, and it is computed in a single register stage with no decomposition into quadratic pieces.

Inside, each of eight share-domains sees exactly one share of each input bit. Together the eight domains hold every share-product of every monomial in the box's algebraic normal form. Two of the domains take their inputs from a single share index and are left as they are. The other six form three complementary pairs, and both members of a pair are masked with the same fresh random nibble. All eight masked nibbles are stored in a register, and only after that register are they folded down to two shares by XOR.

The host presents a new nibble with `in_valid` and reads the result one cycle later, qualified by `out_valid`. It supplies 12 fresh random bits with every valid input.

Top module: `sbox_ti_first_order`

## Requirements
- R1: With `in_valid` high, the value `out_share0 ^ out_share1` in the next cycle equals S(`in_share0 ^ in_share1`). S maps 0..15 to hex B,F,3,2,A,C,9,1,6,7,8,0,E,5,D,4. Bit 0 is the least significant bit of each nibble.
- R2: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high while out of reset.
- R3: The recombined result of R1 does not depend on how the input is split between the two shares, nor on the value of `rnd`.
- R4: While `in_valid` is low, `out_share0` and `out_share1` keep their previous values, whatever the other inputs do.
- R5: A clock edge with `rst_n` low clears `out_valid`, `out_share0` and `out_share1` to zero in the next cycle, even if `in_valid` is high.
- R6: For a fixed input and split, changing `rnd` from 0 to R flips both `out_share0` and `out_share1` by R[3:0] ^ R[7:4] ^ R[11:8]. The three nibbles of `rnd` are the masks of the three complementary domain pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input shares and random bits are valid this cycle |
| in_share0 | input | 4 | First Boolean share of the input nibble |
| in_share1 | input | 4 | Second Boolean share of the input nibble |
| rnd | input | 12 | Fresh random bits, one nibble per domain pair |
| out_valid | output | 1 | Output shares carry the result of the previous valid input |
| out_share0 | output | 4 | First Boolean share of the substituted nibble |
| out_share1 | output | 4 | Second Boolean share of the substituted nibble |

## Verification
All sixteen inputs are first applied with an all-zero second share and zero randomness. This pins the plain mapping and catches any misplaced monomial or constant term. The sweep is repeated with random splits and random bits, which exposes a share product that is missing or counted twice: such an error only shows when the second share is nonzero. Paired runs that differ only in `rnd` separate correct pair masking from a mask that lands in one share group only or does not cancel. Idle cycles with changing inputs, valid pulses and a reset in mid-stream cover the hold, latency and clearing behaviour.

// File: rtl/sbox_ti_pkg.sv
// Package: shared constants and elaboration-time helpers for the masked
// substitution box. Assumes the box has algebraic degree at most three, so
// each cubic monomial is spread one share-product per domain.
package sbox_ti_pkg;

    localparam int NIB_W   = 4;
    localparam int DOMAINS = 8;
    localparam int PAIRS   = 3;
    localparam int RND_W   = PAIRS * NIB_W;
    localparam int MONOS   = 1 << NIB_W;

    typedef logic [NIB_W-1:0] nib_t;

    // Unmasked mapping, entry i in bits [4i+3:4i].
    localparam logic [NIB_W*MONOS-1:0] SUBST_TABLE = 64'h4D5E_0876_19CA_23FB;

    // Share index per input bit for each domain, domain r in bits [4r+3:4r].
    // Domains 2p and 2p+1 are complementary (pair p); 6 and 7 are single-index.
    localparam logic [NIB_W*DOMAINS-1:0] DOMAIN_TUPLE = 32'h0F69_3C5A;

    // Domain that absorbs the constant term of every output bit.
    localparam int CONST_DOMAIN = 6;

    // Plain lookup of the unmasked mapping.
    function automatic nib_t subst(input nib_t v);
        return SUBST_TABLE[NIB_W*int'(v) +: NIB_W];
    endfunction

    // Algebraic normal form of all output bits; bit b uses [16b+15:16b].
    function automatic logic [NIB_W*MONOS-1:0] anf_all();
        logic [NIB_W*MONOS-1:0] res;
        res = '0;
        for (int b = 0; b < NIB_W; b++) begin
            for (int m = 0; m < MONOS; m++) begin
                for (int u = 0; u < MONOS; u++) begin
                    if ((u & ~m) == 0)
                        res[MONOS*b+m] = res[MONOS*b+m] ^ SUBST_TABLE[NIB_W*u+b];
                end
            end
        end
        return res;
    endfunction

    // Monomials whose share-product for this domain's indices is placed here:
    // the first domain that carries the needed indices takes it.
    function automatic logic [MONOS-1:0] keep_mask(input int row);
        logic [MONOS-1:0] res;
        logic [NIB_W-1:0] own;
        logic             first;
        own = DOMAIN_TUPLE[NIB_W*row +: NIB_W];
        for (int m = 0; m < MONOS; m++) begin
            if (m == 0) begin
                res[m] = (row == CONST_DOMAIN);
            end else begin
                first = 1'b1;
                for (int r = 0; r < DOMAINS; r++) begin
                    if (r < row &&
                        ((DOMAIN_TUPLE[NIB_W*r +: NIB_W] ^ own) & 4'(m)) == '0)
                        first = 1'b0;
                end
                res[m] = first;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/sbox_ti_domain_eval.sv
// Module: evaluates the share-nibble of one domain. It picks one share of
// each input bit, as the domain's index tuple says, and sums the
// share-products of the monomials placed in this domain.
// Assumes: purely combinational; the result is registered by the parent.
module sbox_ti_domain_eval
    import sbox_ti_pkg::*;
#(
    parameter int DOMAIN = 0
) (
    input  nib_t sh0,
    input  nib_t sh1,
    output nib_t part
);
    localparam logic [NIB_W-1:0]       TUP  = DOMAIN_TUPLE[NIB_W*DOMAIN +: NIB_W];
    localparam logic [NIB_W*MONOS-1:0] ANF  = anf_all();
    localparam logic [MONOS-1:0]       KEEP = keep_mask(DOMAIN);

    nib_t sel;

    // Select the share of each input bit allowed in this domain.
    assign sel = (TUP & sh1) | (~TUP & sh0);

    // Sum the placed monomial products for each output bit.
    always_comb begin
        part = '0;
        for (int b = 0; b < NIB_W; b++) begin
            for (int m = 0; m < MONOS; m++) begin
                if (ANF[MONOS*b+m] && KEEP[m])
                    part[b] = part[b] ^ (&(sel | ~4'(m)));
            end
        end
    end
endmodule

// File: rtl/sbox_ti_remask.sv
// Module: adds fresh randomness to the domain nibbles. Both members of a
// complementary pair get the same random nibble; single-index domains pass.
// Assumes: rnd is fresh for every valid input.
module sbox_ti_remask
    import sbox_ti_pkg::*;
(
    input  logic [NIB_W*DOMAINS-1:0] raw,
    input  logic [RND_W-1:0]         rnd,
    output logic [NIB_W*DOMAINS-1:0] masked
);
    for (genvar r = 0; r < DOMAINS; r++) begin : g_dom
        if (r < 2*PAIRS) begin : g_pair
            // Mask a paired domain with its pair's random nibble.
            assign masked[NIB_W*r +: NIB_W] =
                raw[NIB_W*r +: NIB_W] ^ rnd[NIB_W*(r/2) +: NIB_W];
        end else begin : g_single
            // Single-index domains are left unmasked.
            assign masked[NIB_W*r +: NIB_W] = raw[NIB_W*r +: NIB_W];
        end
    end
endmodule

// File: rtl/sbox_ti_compress.sv
// Module: folds the eight registered domain nibbles into two output shares.
// Even domains form share 0 and odd domains share 1, so each group holds one
// member of every pair and one single-index domain.
// Assumes: its input comes straight from a register.
module sbox_ti_compress
    import sbox_ti_pkg::*;
(
    input  logic [NIB_W*DOMAINS-1:0] held,
    output nib_t                     share0,
    output nib_t                     share1
);
    // XOR the domains of each group together.
    always_comb begin
        share0 = '0;
        share1 = '0;
        for (int r = 0; r < DOMAINS; r++) begin
            if (r % 2 == 0) share0 = share0 ^ held[NIB_W*r +: NIB_W];
            else            share1 = share1 ^ held[NIB_W*r +: NIB_W];
        end
    end
endmodule

// File: rtl/sbox_ti_first_order.sv
// Module: first-order masked 4-bit substitution box with one register stage.
// Assumes: in_share0/in_share1 are independent shares and rnd is fresh.
module sbox_ti_first_order
    import sbox_ti_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_share0,
    input  logic [3:0]       in_share1,
    input  logic [11:0]      rnd,
    output logic             out_valid,
    output logic [3:0]       out_share0,
    output logic [3:0]       out_share1
);
    logic [NIB_W*DOMAINS-1:0] raw;
    logic [NIB_W*DOMAINS-1:0] masked;
    logic [NIB_W*DOMAINS-1:0] held_q;
    logic                     valid_q;

    for (genvar r = 0; r < DOMAINS; r++) begin : g_eval
        sbox_ti_domain_eval #(.DOMAIN(r)) u_eval (
            .sh0  (in_share0),
            .sh1  (in_share1),
            .part (raw[NIB_W*r +: NIB_W])
        );
    end

    sbox_ti_remask u_remask (
        .raw    (raw),
        .rnd    (rnd),
        .masked (masked)
    );

    // Store all eight masked domains before any recombination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) held_q <= masked;
        end
    end

    sbox_ti_compress u_compress (
        .held   (held_q),
        .share0 (out_share0),
        .share1 (out_share1)
    );

    assign out_valid = valid_q;
endmodule

// File: rtl/sbox_ti_checker.sv
// Module: temporal properties of the masked substitution box, bound to the top.
module sbox_ti_checker
    import sbox_ti_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  in_share0,
    input logic [3:0]  in_share1,
    input logic        out_valid,
    input logic [3:0]  out_share0,
    input logic [3:0]  out_share1
);
    p_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_share0 ^ out_share1) == subst($past(in_share0 ^ in_share1))));

    p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_share0) && $stable(out_share1)));

    p_clear_r5: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_share0 == 4'h0 && out_share1 == 4'h0));
endmodule

bind sbox_ti_first_order sbox_ti_checker u_chk (.*);

// File: tb/sbox_ti_first_order_tb.sv
`timescale 1ns/1ps
module sbox_ti_first_order_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  in_share0 = '0;
    logic [3:0]  in_share1 = '0;
    logic [11:0] rnd = '0;
    logic        out_valid;
    logic [3:0]  out_share0;
    logic [3:0]  out_share1;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    sbox_ti_first_order u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_share0  (in_share0),
        .in_share1  (in_share1),
        .rnd        (rnd),
        .out_valid  (out_valid),
        .out_share0 (out_share0),
        .out_share1 (out_share1)
    );

    function automatic logic [3:0] ref_s(input logic [3:0] v);
        case (v)
            4'h0: return 4'hB;  4'h1: return 4'hF;  4'h2: return 4'h3;  4'h3: return 4'h2;
            4'h4: return 4'hA;  4'h5: return 4'hC;  4'h6: return 4'h9;  4'h7: return 4'h1;
            4'h8: return 4'h6;  4'h9: return 4'h7;  4'hA: return 4'h8;  4'hB: return 4'h0;
            4'hC: return 4'hE;  4'hD: return 4'h5;  4'hE: return 4'hD;  default: return 4'h4;
        endcase
    endfunction

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, return at the next falling edge.
    task automatic step(input logic v, input logic [3:0] s0, input logic [3:0] s1,
                        input logic [11:0] r);
        in_valid  = v;
        in_share0 = s0;
        in_share1 = s1;
        rnd       = r;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b1, 4'h5, 4'h3, 12'hABC);
        step(1'b1, 4'h7, 4'h1, 12'h123);
        check("R5 valid in reset", {11'd0, out_valid}, 12'd0);
        check("R5 shares in reset", {4'd0, out_share0, out_share1}, 12'd0);
        rst_n = 1'b1;
        step(1'b0, 4'h0, 4'h0, 12'h0);
    endtask

    task automatic t_plain_sweep;
        for (int v = 0; v < 16; v++) begin
            step(1'b1, 4'(v), 4'h0, 12'h0);
            check("R1 plain mapping", {8'd0, out_share0 ^ out_share1}, {8'd0, ref_s(4'(v))});
            check("R2 valid after input", {11'd0, out_valid}, 12'd1);
        end
    endtask

    task automatic t_masked_sweep;
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 16; v++) begin
                logic [3:0]  m;
                logic [11:0] r;
                m = 4'($urandom);
                r = 12'($urandom);
                step(1'b1, 4'(v) ^ m, m, r);
                check("R3 masked mapping", {8'd0, out_share0 ^ out_share1}, {8'd0, ref_s(4'(v))});
            end
        end
    endtask

    task automatic t_hold;
        logic [3:0] h0, h1;
        step(1'b1, 4'h9, 4'h6, 12'h5A5);
        h0 = out_share0;
        h1 = out_share1;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, 4'(i * 3 + 1), 4'(i + 7), 12'($urandom));
            check("R4 shares held", {4'd0, out_share0, out_share1}, {4'd0, h0, h1});
            check("R2 valid low when idle", {11'd0, out_valid}, 12'd0);
        end
    endtask

    task automatic t_remask_delta;
        for (int k = 0; k < 6; k++) begin
            logic [3:0]  v, m;
            logic [11:0] r;
            logic [3:0]  b0, b1;
            v = 4'($urandom);
            m = 4'($urandom);
            r = 12'($urandom) | 12'h001;
            step(1'b1, v ^ m, m, 12'h0);
            b0 = out_share0;
            b1 = out_share1;
            step(1'b1, v ^ m, m, r);
            check("R6 share0 flip", {8'd0, out_share0 ^ b0}, {8'd0, r[3:0] ^ r[7:4] ^ r[11:8]});
            check("R6 share1 flip", {8'd0, out_share1 ^ b1}, {8'd0, r[3:0] ^ r[7:4] ^ r[11:8]});
        end
    endtask

    task automatic t_valid_pulses;
        step(1'b1, 4'h2, 4'h4, 12'h111);
        check("R2 pulse high", {11'd0, out_valid}, 12'd1);
        check("R1 pulse value", {8'd0, out_share0 ^ out_share1}, {8'd0, ref_s(4'h6)});
        step(1'b0, 4'h0, 4'h0, 12'h0);
        check("R2 gap low", {11'd0, out_valid}, 12'd0);
        step(1'b1, 4'hE, 4'h3, 12'hF0F);
        check("R2 pulse again", {11'd0, out_valid}, 12'd1);
        check("R1 second pulse value", {8'd0, out_share0 ^ out_share1}, {8'd0, ref_s(4'hD)});
    endtask

    task automatic t_reset_midstream;
        step(1'b1, 4'hC, 4'h1, 12'h777);
        rst_n = 1'b0;
        step(1'b1, 4'h3, 4'h8, 12'h999);
        check("R5 valid cleared", {11'd0, out_valid}, 12'd0);
        check("R5 shares cleared", {4'd0, out_share0, out_share1}, 12'd0);
        rst_n = 1'b1;
        step(1'b0, 4'h0, 4'h0, 12'h0);
        check("R2 valid stays low after reset", {11'd0, out_valid}, 12'd0);
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_plain_sweep();
        t_masked_sweep();
        t_hold();
        t_remask_delta();
        t_valid_pulses();
        t_reset_midstream();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule